// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the device-side end of a three-wire serial link to a small register bank. The link has a serial clock, one shared data line and an optional active-low select. The whole port runs on a fast master clock. The serial clock is limited to one tenth of the master clock or less, and all link pins are oversampled through synchronizers. Every transfer starts with an eight-bit command that the host shifts in. The command picks a direction, a length of one to four bytes and a starting register. The data bytes then follow on the same line. On a write the host drives them. On a read the port drives them.

The shared line is split into three plain ports: an input, an output value and an output enable. The pad buffer sits outside the block. The enable is asserted only while read data is being returned. Raising the select during a read does not cut the enable short. The enable drops only after the last data clock of the transfer. The select can be held low for good. Transfers then follow each other with no framing other than the bit count.

Top module: `tsp_port`

## Requirements
- R1: After reset the output enable is low and every register holds zero. The enable stays low whenever no read data phase is in progress.
- R2: The command is eight bits, most significant bit first. Bit 7 set means read and bit 7 clear means write. Bits 6:5 hold the byte count minus one. Bits 3:0 hold the first register address. Bit 4 has no effect.
- R3: Write data is sampled on falling serial clock edges, MSB first. Each completed byte is stored at the current address. The address then steps up by one and wraps from 15 to 0.
- R4: During a read the output value changes only in response to a rising serial clock edge. Each byte of the addressed registers is sent MSB first, so the host can sample on the falling edge. Consecutive bytes come from consecutive addresses, wrapping from 15 to 0.
- R5: After the falling edge of the last command bit of a read, the output enable rises within 8 master clock cycles. The MSB of the first byte is already present on the output.
- R6: After the falling edge of the last bit of the last read byte, the output enable falls within 6 master clock cycles.
- R7: Raising the select while read data is being sent does not drop the output enable. The read runs to its last byte.
- R8: While the select is high and no data phase is in progress, serial clock edges have no effect. No command is decoded and no register is written.
- R9: A falling edge on the select discards any partial command. The next eight bits are taken as a fresh command.
- R10: With the select held low, a command followed by its data bytes is followed directly by the next command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, at least ten times the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low select, may be tied low |
| sdio_in | input | 1 | Value seen on the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdio_out | output | 1 | Value to drive on the shared data line |

## Verification
The assertions rely on a serial clock slow enough that each synchronized level lasts several master cycles. Under that condition a rising and a falling edge are never seen in the same cycle. The assertions also rely on the host changing data only while the serial clock is high, and on the host never driving the line while the enable is up. The stimulus keeps every serial clock half period at eight master cycles. It changes the data input only before a rising edge. It leaves at least thirty master cycles between a select edge and the next clock activity, and between transfers. The sweep covers every start address with every byte count, including the wrap from 15 to 0.

// File: rtl/tsp_pkg.sv
// Shared types for the three-wire serial register port.
// Assumes an eight-bit command with the field layout given in the brief.
package tsp_pkg;
    localparam int CMD_W  = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_WDATA = 2'd1,
        PH_RDATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [1:0]        len_m1;
        logic              spare;
        logic [ADDR_W-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/tsp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes STAGES >= 2; all stages clear to zero in reset.
module tsp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/tsp_edge.sv
// Brings serial clock, select and data into the master domain and finds
// serial clock and select edges there. Assumes the serial clock stays at
// each level for several master cycles.
module tsp_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdio_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_hi,
    output logic cs_fall,
    output logic din
);
    logic [2:0] synced;
    logic       sclk_s;
    logic       sclk_d;
    logic       cs_d;

    tsp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sdio_in, sclk}),
        .q     (synced)
    );

    assign sclk_s = synced[0];
    assign din    = synced[1];
    assign cs_hi  = synced[2];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_hi;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_fall   = cs_d & ~cs_hi;
endmodule

// File: rtl/tsp_regfile.sv
// Small register bank: one synchronous write port and one combinational
// read port. All entries clear in reset.
module tsp_regfile #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear the bank in reset, otherwise store on write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tsp_ctrl.sv
// Transfer sequencer: decodes the command, counts bits and bytes, issues
// register writes and serializes read data. The select gates only the
// command phase. A started data phase always runs to its last byte.
module tsp_ctrl
    import tsp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_hi,
    input  logic              cs_fall,
    input  logic              din,
    input  logic [DW-1:0]     rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              sdio_oe,
    output logic              sdio_out
);
    localparam int SH_W  = (DW > CMD_W) ? DW : CMD_W;
    localparam int CNT_W = $clog2(SH_W);

    phase_e            phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [SH_W-1:0]   shift;
    logic [1:0]        left;
    logic [ADDR_W-1:0] addr;
    logic              oe_q;
    logic              out_q;

    logic              take_fall;
    logic              last_bit;
    cmd_t              cmd_now;
    logic [CNT_W-1:0]  out_idx;

    // Qualify edges and decode the command as its last bit arrives.
    always_comb begin
        take_fall = sclk_fall && !(cs_hi && phase == PH_CMD);
        last_bit  = (phase == PH_CMD) ? (bitcnt == CNT_W'(CMD_W - 1))
                                      : (bitcnt == CNT_W'(DW - 1));
        cmd_now   = cmd_t'({shift[CMD_W-2:0], din});
        rd_addr   = (phase == PH_CMD) ? cmd_now.addr : addr;
        out_idx   = CNT_W'(DW - 1) - bitcnt;
    end

    assign wr_en    = take_fall && phase == PH_WDATA && last_bit;
    assign wr_addr  = addr;
    assign wr_data  = {shift[DW-2:0], din};
    assign sdio_oe  = oe_q;
    assign sdio_out = out_q;

    // Phase, counters, shift register and pin driver state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
            shift  <= '0;
            left   <= '0;
            addr   <= '0;
            oe_q   <= 1'b0;
            out_q  <= 1'b0;
        end else if (cs_fall) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (take_fall) begin
            shift  <= {shift[SH_W-2:0], din};
            bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
            if (last_bit) begin
                unique case (phase)
                    PH_CMD: begin
                        addr <= cmd_now.addr;
                        left <= cmd_now.len_m1;
                        if (cmd_now.rd) begin
                            phase <= PH_RDATA;
                            oe_q  <= 1'b1;
                            out_q <= rd_data[DW-1];
                        end else begin
                            phase <= PH_WDATA;
                        end
                    end
                    PH_WDATA, PH_RDATA: begin
                        if (left == 2'd0) begin
                            phase <= PH_CMD;
                            oe_q  <= 1'b0;
                        end else begin
                            left <= left - 1'b1;
                            addr <= addr + 1'b1;
                        end
                    end
                    default: phase <= PH_CMD;
                endcase
            end
        end else if (sclk_rise && phase == PH_RDATA) begin
            out_q <= rd_data[out_idx];
        end
    end
endmodule

// File: rtl/tsp_port.sv
// Top of the three-wire serial register port. The shared data line is
// split into input, output value and enable; the pad lives outside.
module tsp_port
    import tsp_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdio_in,
    output logic sdio_oe,
    output logic sdio_out
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_hi;
    logic              cs_fall;
    logic              din;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DW-1:0]     wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DW-1:0]     rd_data;

    tsp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdio_in   (sdio_in),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_hi     (cs_hi),
        .cs_fall   (cs_fall),
        .din       (din)
    );

    tsp_regfile #(.DW(DW), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    tsp_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_hi     (cs_hi),
        .cs_fall   (cs_fall),
        .din       (din),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdio_oe   (sdio_oe),
        .sdio_out  (sdio_out)
    );
endmodule

// File: rtl/tsp_port_chk.sv
// Protocol checker for tsp_port, attached through bind. Relates the pin
// driver to the synchronized serial clock and select events.
module tsp_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sdio_oe,
    input logic sdio_out,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic cs_hi,
    input logic cs_fall,
    input logic wr_en
);
    AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !wr_en); // R1

    AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sclk_fall); // R3

    AST_OUT_HOLDS_WITHOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && $past(sdio_oe) && !$past(sclk_rise)) |-> $stable(sdio_out)); // R4

    AST_TURN_ON_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(sclk_fall)); // R5

    AST_TURN_OFF_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe) |-> ($past(sclk_fall) || $past(cs_fall))); // R6

    AST_SELECT_RISE_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && $rose(cs_hi) && !sclk_fall) |=> sdio_oe); // R7
endmodule

bind tsp_port tsp_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdio_oe   (sdio_oe),
    .sdio_out  (sdio_out),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_hi     (cs_hi),
    .cs_fall   (cs_fall),
    .wr_en     (wr_en)
);

// File: tb/tsp_port_bench.sv
// Self-checking bench: writes the whole bank, then reads back every start
// address with every length, plus select corner cases.
module tsp_port_bench;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic sclk;
    logic cs_n;
    logic sdio_in;
    logic sdio_oe;
    logic sdio_out;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [16];

    always #2.5 clk = ~clk;

    tsp_port u_tsp_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdio_in  (sdio_in),
        .sdio_oe  (sdio_oe),
        .sdio_out (sdio_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        sdio_in = b;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic get_byte(input logic last, input string tag, output logic [7:0] v);
        logic oe_ok;
        oe_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b1;
            wait_clk(HALF);
            v[i] = sdio_out;
            if (sdio_oe !== 1'b1) oe_ok = 1'b0;
            sclk = 1'b0;
            if (last && i == 0) begin
                wait_clk(6);
                chk("R6 enable off after last data bit", sdio_oe, 1'b0);
                wait_clk(HALF - 6);
            end else begin
                wait_clk(HALF);
            end
        end
        chk({tag, " enable held through byte"}, oe_ok, 1'b1);
    endtask

    task automatic do_write(input logic [3:0] a, input int n, input logic spare,
                            input logic use_cs, input int seed, input string tag);
        logic [3:0] idx;
        logic [7:0] val;
        if (use_cs) cs_n = 1'b0;
        wait_clk(30);
        put_byte({1'b0, 2'(n - 1), spare, a});
        for (int k = 0; k < n; k++) begin
            idx = a + 4'(k);
            val = 8'((int'(idx) * seed + 5) & 8'hff);
            put_byte(val);
            model[idx] = val;
        end
        chk({tag, " enable stays low in write"}, sdio_oe, 1'b0);
        if (use_cs) cs_n = 1'b1;
        wait_clk(45);
    endtask

    task automatic do_read(input logic [3:0] a, input int n, input logic use_cs,
                           input logic raise, input string tag);
        logic [3:0] idx;
        logic [7:0] got;
        if (use_cs) cs_n = 1'b0;
        wait_clk(30);
        put_byte({1'b1, 2'(n - 1), 1'b0, a});
        chk("R5 enable on after command", sdio_oe, 1'b1);
        chk("R5 first bit present at turn-on", sdio_out, model[a][7]);
        if (raise) cs_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            idx = a + 4'(k);
            get_byte(k == n - 1, tag, got);
            chk({tag, " read byte"}, got, model[idx]);
        end
        if (use_cs) cs_n = 1'b1;
        wait_clk(45);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        rst_n = 1'b0;
        sclk = 1'b0;
        cs_n = 1'b1;
        sdio_in = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R1 enable low after reset", sdio_oe, 1'b0);

        // R1: registers read back as zero before any write
        do_read(4'd0, 4, 1'b1, 1'b0, "R1");

        // R2/R3: fill the bank, bit 4 toggled, last write wraps 15 -> 0
        for (int s = 2; s < 14; s += 4)
            do_write(4'(s), 4, 1'(s >> 2), 1'b1, 37, "R3");
        do_write(4'd14, 4, 1'b1, 1'b1, 37, "R3");

        // R2/R3/R4: every start address with every length
        for (int a = 0; a < 16; a++)
            for (int n = 1; n <= 4; n++)
                do_read(4'(a), n, 1'b1, 1'b0, "R4");

        // R7: select raised right after turn-on, read still completes
        do_read(4'd3, 2, 1'b1, 1'b1, "R7");

        // R8: edges with select high are ignored
        cs_n = 1'b1;
        wait_clk(30);
        put_byte({1'b1, 2'd3, 1'b0, 4'd6});
        wait_clk(6);
        chk("R8 no turn-on with select high", sdio_oe, 1'b0);
        put_byte({1'b0, 2'd0, 1'b0, 4'd6});
        put_byte(8'h5a);
        wait_clk(30);
        do_read(4'd6, 1, 1'b1, 1'b0, "R8");

        // R9: partial command discarded by select falling edge
        cs_n = 1'b0;
        wait_clk(30);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        cs_n = 1'b1;
        wait_clk(30);
        do_read(4'd9, 1, 1'b1, 1'b0, "R9");

        // R10: select tied low, transfers back to back
        cs_n = 1'b0;
        wait_clk(30);
        do_write(4'd15, 2, 1'b0, 1'b0, 11, "R10");
        do_read(4'd15, 2, 1'b0, 1'b0, "R10");
        do_read(4'd14, 3, 1'b0, 1'b0, "R10");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule